// File: doc/BRIEF.md
# SPI NOR Flash Target Emulator

This block is a synthesizable serial-flash target for exercising flash host controllers. It listens on a single-bit SPI link (mode 0: clock idles low, the host samples on the rising edge, the target changes its output on the falling edge). It holds a small byte array that behaves like NOR flash. All link inputs are synchronised into the system clock. The serial clock must therefore run well below the system clock; each SCK half period needs at least six system clocks.

The emulator decodes six one-byte opcodes:

| Opcode | Command |
|--------|---------|
| 0x06 | set write enable |
| 0x05 | read status |
| 0x03 | read data |
| 0x02 | page program |
| 0xD8 | sector erase |
| 0xC7 | whole-array erase |

It enforces the write rules a real part imposes. Programming can only clear bits. Erasing restores whole regions to ones. Program and erase need the write-enable flag. A busy flag stays up for a programmable number of system clocks after each program or erase. Program and erase act only when chip select rises on a byte boundary. The page data is held in a page-sized staging buffer until then.

Two state machines do the work. The frame machine has the states `F_IDLE`, `F_ADDR`, `F_READ`, `F_PROG`, `F_STAT`, `F_CMD` and `F_SKIP`. Its transitions are:

- **Return to idle.** Any chip-select edge sends it to `F_IDLE`.
- **Opcode decode from `F_IDLE`.**
  - Read status goes to `F_STAT`.
  - Any other opcode while busy goes to `F_SKIP`.
  - Write enable goes to `F_CMD`.
  - Read data goes to `F_ADDR`.
  - Page program and sector erase go to `F_ADDR` if the write-enable flag is set, otherwise to `F_SKIP`.
  - Whole-array erase goes to `F_CMD` if the write-enable flag is set, otherwise to `F_SKIP`.
  - Unknown opcodes go to `F_SKIP`.
- **After the third address byte in `F_ADDR`.** Read goes to `F_READ`, program goes to `F_PROG`, and erase goes to `F_CMD`.

The operation machine has the states `O_IDLE`, `O_PROG`, `O_ERASE` and `O_WAIT`. Its transitions are:

- **Start.** An aligned frame end in `F_PROG` moves it from `O_IDLE` to `O_PROG`. An aligned frame end in `F_CMD` with an erase opcode moves it to `O_ERASE`.
- **Sweep.** `O_PROG` and `O_ERASE` sweep one byte per clock. They move to `O_WAIT` after the last byte.
- **Finish.** `O_WAIT` returns to `O_IDLE` when the busy timer has expired. The write-enable flag clears at that moment.

Top module: `nor_flash_emu`

## Requirements
- R1: After reset the status byte reads 0x00 and every array byte reads 0xFF.
- R2: Read status (0x05) returns one status byte after each opcode byte, repeated for as long as the frame lasts. Bit 0 of the status byte is the busy flag and bit 1 is the write-enable flag; bits 7..2 are 0.
- R3: A write-enable frame (0x06) that ends on a byte boundary sets the write-enable flag.
- R4: Read data (0x03) is followed by a 24-bit address, most significant byte first.
  - The address is taken modulo the array size.
  - Data bytes stream out, most significant bit first, starting at that address.
  - The address increments after each byte and wraps from the last array byte to byte 0.
- R5: Page program (0x02) takes a 24-bit address and then data bytes. Each addressed byte becomes its old value ANDed with the data, so bits only go from 1 to 0.
- R6: Program data that runs past a 256-byte page boundary wraps to the start of the same page. Bytes outside that page are untouched.
- R7: Sector erase (0xD8 plus a 24-bit address) sets every byte of the 512-byte sector containing the address to 0xFF. Whole-array erase (0xC7) sets every array byte to 0xFF.
- R8: Program and erase frames sent while the write-enable flag is clear change nothing: the array keeps its contents and the busy flag stays 0.
- R9: After an accepted program or erase, the busy flag reads 1 for at least PROG_CYCLES or ERASE_CYCLES system clocks, then reads 0. The write-enable flag clears at completion.
- R10: While busy, every opcode except read status is ignored; in particular a page program sent during an erase leaves the array unchanged.
- R11: A program frame whose chip select rises mid-byte is discarded. The array is unchanged, no busy period starts, and the write-enable flag stays set.
- R12: The serial clock may stop for any time while chip select stays low; the frame resumes at the same bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host, idles low |
| cs_n | input | 1 | Active-low chip select from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
The embedded assertions watch, on every clock, the following invariants:

- a busy period never starts without the write-enable flag;
- busy never drops before the timer has run out;
- the write-enable flag is clear whenever busy falls;
- any non-status opcode seen while busy is steered to the skip state;
- a program write never raises a bit;
- an erase write leaves 0xFF behind.

The directed scenarios are needed for the behaviour that only shows at the pins. This covers:

- the AND result of repeated programming;
- wrap-around within a page and across the array end;
- the extent of a sector erase compared with a whole-array erase;
- refusal of writes without the write-enable flag;
- discarding of a frame cut mid-byte;
- survival of a long clock pause inside a frame.

// File: rtl/nor_emu_pkg.sv
package nor_emu_pkg;

    localparam logic [7:0] CMD_WREN = 8'h06;
    localparam logic [7:0] CMD_RDSR = 8'h05;
    localparam logic [7:0] CMD_READ = 8'h03;
    localparam logic [7:0] CMD_PP   = 8'h02;
    localparam logic [7:0] CMD_SE   = 8'hD8;
    localparam logic [7:0] CMD_BE   = 8'hC7;

    typedef enum logic [2:0] {
        F_IDLE,
        F_ADDR,
        F_READ,
        F_PROG,
        F_STAT,
        F_CMD,
        F_SKIP
    } frame_st_t;

    typedef enum logic [1:0] {
        O_IDLE,
        O_PROG,
        O_ERASE,
        O_WAIT
    } op_st_t;

endpackage

// File: rtl/nor_spi_port.sv
module nor_spi_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_next,
    output logic       miso,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       frame_start,
    output logic       frame_end,
    output logic       frame_aligned
);
    logic [2:0] sck_s;
    logic [2:0] cs_s;
    logic [1:0] mosi_s;
    logic [2:0] bitcnt;
    logic [6:0] in_sh;
    logic [7:0] out_sh;
    logic       sck_rise;
    logic       sck_fall;
    logic       in_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_s  <= 3'b000;
            cs_s   <= 3'b111;
            mosi_s <= 2'b00;
        end else begin
            sck_s  <= {sck_s[1:0], sck};
            cs_s   <= {cs_s[1:0], cs_n};
            mosi_s <= {mosi_s[0], mosi};
        end
    end

    assign sck_rise      = sck_s[1] & ~sck_s[2];
    assign sck_fall      = ~sck_s[1] & sck_s[2];
    assign in_frame      = ~cs_s[1];
    assign frame_start   = ~cs_s[1] & cs_s[2];
    assign frame_end     = cs_s[1] & ~cs_s[2];
    assign frame_aligned = (bitcnt == 3'd0);
    assign rx_valid      = sck_rise && in_frame && (bitcnt == 3'd7);
    assign rx_byte       = {in_sh, mosi_s[1]};
    assign miso          = out_sh[7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt <= 3'd0;
            in_sh  <= 7'd0;
            out_sh <= 8'hFF;
        end else if (frame_start) begin
            bitcnt <= 3'd0;
        end else if (in_frame) begin
            if (sck_rise) begin
                in_sh  <= {in_sh[5:0], mosi_s[1]};
                bitcnt <= bitcnt + 3'd1;
            end
            if (sck_fall) begin
                out_sh <= (bitcnt == 3'd0) ? tx_next : {out_sh[6:0], 1'b1};
            end
        end
    end

endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] remaining;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                remaining <= '0;
        else if (start)            remaining <= load_val;
        else if (remaining != '0)  remaining <= remaining - 1'b1;
    end

    assign done = (remaining == '0);

endmodule

// File: rtl/nor_store.sv
module nor_store #(
    parameter int MEM_BYTES = 2048,
    localparam int AW = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    input  logic          wr_en,
    input  logic          wr_erase,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data
);
    logic [7:0] mem [MEM_BYTES];
    logic [7:0] old_byte;

    assign rd_data  = mem[rd_addr];
    assign old_byte = mem[wr_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_erase ? 8'hFF : (old_byte & wr_data);
        end
    end

    // R5: a program write never raises a bit
    assert_prog_no_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_erase) |=> ((mem[$past(wr_addr)] & ~$past(old_byte)) == 8'h00));

    // R7: an erase write leaves all ones
    assert_erase_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_erase) |=> (mem[$past(wr_addr)] == 8'hFF));

endmodule

// File: rtl/nor_flash_emu.sv
module nor_flash_emu #(
    parameter int MEM_BYTES    = 2048,
    parameter int SECTOR_BYTES = 512,
    parameter int PAGE_BYTES   = 256,
    parameter int PROG_CYCLES  = 300,
    parameter int ERASE_CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic miso
);
    import nor_emu_pkg::*;

    localparam int AW    = $clog2(MEM_BYTES);
    localparam int PW    = $clog2(PAGE_BYTES);
    localparam int MAXC  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW    = $clog2(MAXC + 1);
    localparam logic [AW-1:0] PAGE_MASK = AW'(PAGE_BYTES - 1);
    localparam logic [AW-1:0] SECT_MASK = AW'(SECTOR_BYTES - 1);
    localparam logic [AW-1:0] MEM_LAST  = AW'(MEM_BYTES - 1);

    // link side
    logic       rx_valid, frame_start, frame_end, frame_aligned;
    logic [7:0] rx_byte;
    logic [7:0] tx_next;

    // frame machine
    frame_st_t  fstate, fnext;
    logic [7:0] cmd_q;
    logic [1:0] abyte_cnt;
    logic [15:0] addr_hi;
    logic [23:0] addr24;
    logic [AW-1:0] full_addr, ptr, start_addr;
    logic [PW-1:0] poff;
    logic [7:0] pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    logic       wel;

    // operation machine
    op_st_t     ostate, onext;
    logic [AW-1:0] idx, sweep_base, sweep_last;
    logic       start_prog, start_erase, tmr_done, busy;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic       wr_en, wr_erase;
    logic [7:0] status;

    nor_spi_port u_port (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .tx_next(tx_next), .miso(miso), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .frame_start(frame_start), .frame_end(frame_end), .frame_aligned(frame_aligned)
    );

    nor_busy_timer #(.CNT_W(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start_prog | start_erase),
        .load_val(start_prog ? CW'(PROG_CYCLES) : CW'(ERASE_CYCLES)),
        .done(tmr_done)
    );

    nor_store #(.MEM_BYTES(MEM_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_erase(wr_erase), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assign busy      = (ostate != O_IDLE);
    assign status    = {6'd0, wel, busy};
    assign addr24    = {addr_hi, rx_byte};
    assign full_addr = addr24[AW-1:0];
    assign rd_addr   = (fstate == F_ADDR) ? full_addr : ptr;

    assign start_prog  = frame_end && frame_aligned && (fstate == F_PROG);
    assign start_erase = frame_end && frame_aligned && (fstate == F_CMD) &&
                         ((cmd_q == CMD_SE) || (cmd_q == CMD_BE));

    // ---------------- frame machine: next state ----------------
    always_comb begin
        fnext = fstate;
        unique case (fstate)
            F_IDLE: if (rx_valid) begin
                if (rx_byte == CMD_RDSR)      fnext = F_STAT;
                else if (busy)                fnext = F_SKIP;
                else if (rx_byte == CMD_WREN) fnext = F_CMD;
                else if (rx_byte == CMD_READ) fnext = F_ADDR;
                else if (rx_byte == CMD_PP || rx_byte == CMD_SE)
                    fnext = wel ? F_ADDR : F_SKIP;
                else if (rx_byte == CMD_BE)   fnext = wel ? F_CMD : F_SKIP;
                else                          fnext = F_SKIP;
            end
            F_ADDR: if (rx_valid && abyte_cnt == 2'd2) begin
                if (cmd_q == CMD_READ)     fnext = F_READ;
                else if (cmd_q == CMD_PP)  fnext = F_PROG;
                else                       fnext = F_CMD;
            end
            F_READ, F_PROG, F_STAT, F_CMD, F_SKIP: fnext = fstate;
            default: fnext = F_IDLE;
        endcase
        if (frame_start || frame_end) fnext = F_IDLE;
    end

    // ---------------- operation machine: next state ----------------
    always_comb begin
        onext = ostate;
        unique case (ostate)
            O_IDLE:  if (start_prog) onext = O_PROG;
                     else if (start_erase) onext = O_ERASE;
            O_PROG,
            O_ERASE: if (idx == sweep_last) onext = O_WAIT;
            O_WAIT:  if (tmr_done) onext = O_IDLE;
            default: onext = O_IDLE;
        endcase
    end

    // ---------------- state registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fstate <= F_IDLE;
            ostate <= O_IDLE;
        end else begin
            fstate <= fnext;
            ostate <= onext;
        end
    end

    // ---------------- frame datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q      <= 8'h00;
            abyte_cnt  <= 2'd0;
            addr_hi    <= 16'd0;
            ptr        <= '0;
            start_addr <= '0;
            poff       <= '0;
            pvalid     <= '0;
            tx_next    <= 8'hFF;
        end else if (rx_valid) begin
            unique case (fstate)
                F_IDLE: begin
                    cmd_q     <= rx_byte;
                    abyte_cnt <= 2'd0;
                    if (rx_byte == CMD_RDSR) tx_next <= status;
                end
                F_ADDR: begin
                    abyte_cnt <= abyte_cnt + 2'd1;
                    addr_hi   <= {addr_hi[7:0], rx_byte};
                    if (abyte_cnt == 2'd2) begin
                        start_addr <= full_addr;
                        ptr        <= (full_addr == MEM_LAST) ? '0 : full_addr + 1'b1;
                        poff       <= full_addr[PW-1:0];
                        tx_next    <= rd_data;
                        if (cmd_q == CMD_PP) pvalid <= '0;
                    end
                end
                F_READ: begin
                    tx_next <= rd_data;
                    ptr     <= (ptr == MEM_LAST) ? '0 : ptr + 1'b1;
                end
                F_PROG: begin
                    pvalid[poff] <= 1'b1;
                    poff         <= poff + 1'b1;
                end
                F_STAT: tx_next <= status;
                F_CMD, F_SKIP: tx_next <= 8'hFF;
                default: tx_next <= 8'hFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rx_valid && fstate == F_PROG) pbuf[poff] <= rx_byte;
    end

    // ---------------- write-enable flag ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wel <= 1'b0;
        else if (ostate == O_WAIT && tmr_done)
            wel <= 1'b0;
        else if (frame_end && frame_aligned && fstate == F_CMD && cmd_q == CMD_WREN)
            wel <= 1'b1;
    end

    // ---------------- sweep registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx        <= '0;
            sweep_base <= '0;
            sweep_last <= '0;
        end else if (ostate == O_IDLE) begin
            idx <= '0;
            if (start_prog) begin
                sweep_base <= start_addr & ~PAGE_MASK;
                sweep_last <= PAGE_MASK;
            end else if (start_erase && cmd_q == CMD_SE) begin
                sweep_base <= start_addr & ~SECT_MASK;
                sweep_last <= SECT_MASK;
            end else if (start_erase) begin
                sweep_base <= '0;
                sweep_last <= MEM_LAST;
            end
        end else if (ostate == O_PROG || ostate == O_ERASE) begin
            idx <= idx + 1'b1;
        end
    end

    // ---------------- operation outputs ----------------
    always_comb begin
        wr_addr  = sweep_base + idx;
        wr_data  = pbuf[idx[PW-1:0]];
        wr_en    = 1'b0;
        wr_erase = 1'b0;
        unique case (ostate)
            O_PROG:  wr_en = pvalid[idx[PW-1:0]];
            O_ERASE: begin wr_en = 1'b1; wr_erase = 1'b1; end
            O_IDLE, O_WAIT: wr_en = 1'b0;
            default: wr_en = 1'b0;
        endcase
    end

    // ---------------- assertions ----------------
    // R8: a busy period only starts with the write-enable flag set
    assert_busy_needs_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wel);

    // R9: busy holds until the timer has expired
    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tmr_done) |=> busy);

    // R9: completion clears the write-enable flag
    assert_done_clears_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R10: non-status opcodes during busy are skipped
    assert_skip_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rx_valid && fstate == F_IDLE && !frame_start && !frame_end &&
         rx_byte != CMD_RDSR) |=> (fstate == F_SKIP));

endmodule

// File: tb/test_nor_flash_emu.sv
module test_nor_flash_emu;

    localparam int PROG_CYCLES  = 300;
    localparam int ERASE_CYCLES = 600;
    localparam int HALF         = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    logic [7:0] last_in;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nor_flash_emu #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) i_nor_flash_emu (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int exp);
        n_tests++;
        if (act < exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected at least %0d", req, act, exp);
        end
    endtask

    task automatic spi_bits(input logic [7:0] o, input int hi, input int lo);
        for (int b = hi; b >= lo; b--) begin
            @(negedge clk);
            mosi = o[b];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            last_in[b] = miso;
            sck = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] o);
        spi_bits(o, 7, 0);
    endtask

    task automatic cs_low();
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic send_addr(input logic [23:0] a);
        spi_byte(a[23:16]); spi_byte(a[15:8]); spi_byte(a[7:0]);
    endtask

    task automatic rdsr(output logic [7:0] s);
        cs_low(); spi_byte(8'h05); spi_byte(8'h00); s = last_in; cs_high();
    endtask

    task automatic wren();
        cs_low(); spi_byte(8'h06); cs_high();
    endtask

    task automatic read_mem(input logic [23:0] a, input int n);
        cs_low(); spi_byte(8'h03); send_addr(a);
        for (int k = 0; k < n; k++) begin spi_byte(8'h00); rbuf[k] = last_in; end
        cs_high();
    endtask

    task automatic prog(input logic [23:0] a, input int n);
        cs_low(); spi_byte(8'h02); send_addr(a);
        for (int k = 0; k < n; k++) spi_byte(wbuf[k]);
        cs_high();
    endtask

    task automatic erase_cmd(input logic [7:0] op, input logic [23:0] a, input bit with_addr);
        cs_low(); spi_byte(op); if (with_addr) send_addr(a); cs_high();
    endtask

    task automatic wait_idle(output int elapsed);
        logic [7:0] s;
        int t0;
        t0 = cyc;
        s = 8'h01;
        while (s[0] === 1'b1) rdsr(s);
        elapsed = cyc - t0;
    endtask

    task automatic t_reset();
        logic [7:0] s;
        rdsr(s); chk("R1 status after reset", s, 8'h00);
        read_mem(24'h000010, 2);
        chk("R1 erased byte 0x010", rbuf[0], 8'hFF);
        chk("R1 erased byte 0x011", rbuf[1], 8'hFF);
    endtask

    task automatic t_wren();
        wren();
        cs_low(); spi_byte(8'h05);
        spi_byte(8'h00); chk("R3 WEL set, first status", last_in, 8'h02);
        spi_byte(8'h00); chk("R2 status repeats", last_in, 8'h02);
        cs_high();
    endtask

    task automatic t_program();
        logic [7:0] s;
        int el, t0;
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'hF0;
        prog(24'h000100, 3);
        t0 = cyc;
        rdsr(s); chk("R9 busy after program", s, 8'h03);
        wait_idle(el);
        chk_ge("R9 program busy length", cyc - t0, PROG_CYCLES);
        rdsr(s); chk("R9 WEL cleared after program", s, 8'h00);
        read_mem(24'h000100, 3);
        chk("R5 byte0", rbuf[0], 8'hA5);
        chk("R5 byte1", rbuf[1], 8'h3C);
        chk("R5 byte2", rbuf[2], 8'hF0);
        wren();
        wbuf[0] = 8'h0F; wbuf[1] = 8'hFF; wbuf[2] = 8'h0F;
        prog(24'h000100, 3);
        wait_idle(el);
        read_mem(24'h000100, 3);
        chk("R5 AND byte0", rbuf[0], 8'h05);
        chk("R5 AND byte1", rbuf[1], 8'h3C);
        chk("R5 AND byte2", rbuf[2], 8'h00);
    endtask

    task automatic t_page_wrap();
        int el;
        wren();
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        prog(24'h0002FE, 4);
        wait_idle(el);
        read_mem(24'h0002FE, 2);
        chk("R6 0x2FE", rbuf[0], 8'h11);
        chk("R6 0x2FF", rbuf[1], 8'h22);
        read_mem(24'h000200, 2);
        chk("R6 wrapped to 0x200", rbuf[0], 8'h33);
        chk("R6 wrapped to 0x201", rbuf[1], 8'h44);
        read_mem(24'h000300, 1);
        chk("R6 next page untouched", rbuf[0], 8'hFF);
    endtask

    task automatic t_no_wel();
        logic [7:0] s;
        wbuf[0] = 8'h00;
        prog(24'h000400, 1);
        rdsr(s); chk("R8 program without WEL not busy", s, 8'h00);
        read_mem(24'h000400, 1);
        chk("R8 program without WEL", rbuf[0], 8'hFF);
        erase_cmd(8'hD8, 24'h000100, 1'b1);
        rdsr(s); chk("R8 erase without WEL not busy", s, 8'h00);
        read_mem(24'h000100, 1);
        chk("R8 erase without WEL", rbuf[0], 8'h05);
    endtask

    task automatic t_sector_erase();
        int el, t0;
        wren();
        erase_cmd(8'hD8, 24'h000180, 1'b1);
        t0 = cyc;
        wait_idle(el);
        chk_ge("R9 erase busy length", cyc - t0, ERASE_CYCLES);
        read_mem(24'h000100, 2);
        chk("R7 sector erased 0x100", rbuf[0], 8'hFF);
        chk("R7 sector erased 0x101", rbuf[1], 8'hFF);
        read_mem(24'h000200, 1);
        chk("R7 neighbour sector kept", rbuf[0], 8'h33);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] s;
        int el;
        wren();
        erase_cmd(8'hC7, 24'h0, 1'b0);
        wbuf[0] = 8'h00;
        prog(24'h000600, 1);
        rdsr(s); chk("R10 still busy during bulk erase", s, 8'h03);
        wait_idle(el);
        read_mem(24'h000600, 1);
        chk("R10 program during busy ignored", rbuf[0], 8'hFF);
        read_mem(24'h000200, 1);
        chk("R7 bulk erase 0x200", rbuf[0], 8'hFF);
        read_mem(24'h0002FE, 1);
        chk("R7 bulk erase 0x2FE", rbuf[0], 8'hFF);
        rdsr(s); chk("R9 WEL cleared after bulk erase", s, 8'h00);
    endtask

    task automatic t_partial();
        logic [7:0] s;
        wren();
        cs_low(); spi_byte(8'h02); send_addr(24'h000500); spi_byte(8'h00);
        spi_bits(8'h00, 7, 5);
        cs_high();
        rdsr(s); chk("R11 cut frame: no busy, WEL kept", s, 8'h02);
        read_mem(24'h000500, 1);
        chk("R11 cut frame discarded", rbuf[0], 8'hFF);
    endtask

    task automatic t_pause();
        int el;
        cs_low(); spi_byte(8'h02); send_addr(24'h000700);
        spi_bits(8'hA1, 7, 4);
        repeat (400) @(negedge clk);
        spi_bits(8'hA1, 3, 0);
        spi_byte(8'hB2);
        cs_high();
        wait_idle(el);
        read_mem(24'h000700, 2);
        chk("R12 paused byte", rbuf[0], 8'hA1);
        chk("R12 byte after pause", rbuf[1], 8'hB2);
    endtask

    task automatic t_read_wrap();
        int el;
        wren();
        wbuf[0] = 8'h5A;
        prog(24'h0007FF, 1);
        wait_idle(el);
        read_mem(24'h0107FF, 2);
        chk("R4 last byte via high address", rbuf[0], 8'h5A);
        chk("R4 wrap to byte 0", rbuf[1], 8'hFF);
        read_mem(24'h0006FF, 3);
        chk("R4 stream 0x6FF", rbuf[0], 8'hFF);
        chk("R4 stream 0x700", rbuf[1], 8'hA1);
        chk("R4 stream 0x701", rbuf[2], 8'hB2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_wren();
        t_program();
        t_page_wrap();
        t_no_wel();
        t_sector_erase();
        t_busy_ignore();
        t_partial();
        t_pause();
        t_read_wrap();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule